// File: doc/BRIEF.md
# Legacy ISA Interrupt Aggregator

This block gathers eleven edge-triggered legacy ISA interrupt request lines into latched status bits. The ISA numbers 3 to 7, 9 to 12, 14 and 15 each own one status bit. The numbers 0, 1, 2, 8 and 13 own none. The status bits sit in two byte-wide registers, a low one and a high one. The host reads them over a small register bus and clears bits by writing ones. Each register is cleared on its own.

An enable mask is ANDed with the status to form the pending vector. A single host interrupt line stays high while any enabled bit is pending. A priority encoder picks the lowest pending bit index and converts it back to its ISA IRQ number, so a dispatcher can read which source to serve next without scanning the registers.

Top module: `isa_irq_aggr`

## Requirements
- R1: A rising edge on `isa_irq[n]` sets one status bit. IRQs 3..7 set bits 0..4. IRQs 10, 11 and 12 set bits 5, 6 and 7. IRQ 9 sets bit 8. IRQs 14 and 15 set bits 9 and 10.
- R2: Edges on `isa_irq` lines 0, 1, 2, 8 and 13 set no status bit.
- R3: A status bit sets only on a rising edge of its input. A line that is held high does not set the bit again after the bit has been cleared. The status changes only through an edge or a write.
- R4: Reading address 0 returns status bits 7..0. Reading address 1 returns status bits 10..8 in data bits 2..0, with data bits 7..3 reading as zero.
- R5: Writing to address 0 clears each low status bit whose data bit is 1. Writing to address 1 clears high status bits 10..8 for data bits 2..0. A write to one address leaves the other register unchanged, and data bits that are 0 clear nothing.
- R6: When a set edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: Enable bits 7..0 are written and read at address 2. Enable bits 10..8 are written and read at address 3 in data bits 2..0.
- R8: `host_irq` is high exactly while some status bit and its enable bit are both 1. A status bit that is set but not enabled leaves `host_irq` low.
- R9: `svc_valid` equals `host_irq`. `svc_irq` gives the ISA IRQ number of the lowest-indexed pending bit.
- R10: A synchronous reset clears all status bits and all enable bits.
- R11: Once an input's rising edge is applied, the matching status bit reads as set no later than the 4th rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| isa_irq | input | 16 | ISA request lines, indexed by ISA IRQ number, asynchronous |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 2 | Register address: 0 status low, 1 status high, 2 enable low, 3 enable high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| host_irq | output | 1 | Summary interrupt to the host |
| svc_valid | output | 1 | A pending source exists |
| svc_irq | output | 4 | ISA IRQ number of the highest-priority pending source |

## Verification
A status bit latched in the wrong position shows up as a wrong byte on the next status read. It also shows up at once as a wrong `svc_irq` number when that bit is the lowest enabled one. A clear that does not take effect, or a set lost to a simultaneous write, shows up within one cycle as `host_irq` staying high or low against expectation. A broken edge detector shows up a few cycles after the input rises: the bit either fails to appear, or reappears after a clear while the line is still held high.

// File: rtl/isa_agg_pkg.sv
`timescale 1ns/1ps
package isa_agg_pkg;
    localparam int NUM_SRC  = 11;
    localparam int LO_W     = 8;
    localparam int HI_W     = NUM_SRC - LO_W;
    localparam int NUM_ISA  = 16;
    localparam int IRQ_W    = $clog2(NUM_ISA);
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int SYNC_STG = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_STS_LO = 2'd0,
        REG_STS_HI = 2'd1,
        REG_EN_LO  = 2'd2,
        REG_EN_HI  = 2'd3
    } reg_sel_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic             valid;
        logic [IRQ_W-1:0] irq;
    } svc_t;

    // Status bit index to ISA IRQ number; the order sets service priority.
    function automatic logic [IRQ_W-1:0] bit_to_irq(input int b);
        case (b)
            0:       return 4'd3;
            1:       return 4'd4;
            2:       return 4'd5;
            3:       return 4'd6;
            4:       return 4'd7;
            5:       return 4'd10;
            6:       return 4'd11;
            7:       return 4'd12;
            8:       return 4'd9;
            9:       return 4'd14;
            default: return 4'd15;
        endcase
    endfunction
endpackage

// File: rtl/isa_edge_sync.sv
`timescale 1ns/1ps
module isa_edge_sync
    import isa_agg_pkg::*;
#(
    parameter int WIDTH  = NUM_SRC,
    parameter int STAGES = SYNC_STG
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= raw;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign rise = stage_q[STAGES-1] & ~prev_q;

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((rise & $past(rise)) == '0)); // R3
endmodule

// File: rtl/isa_status_regs.sv
`timescale 1ns/1ps
module isa_status_regs
    import isa_agg_pkg::*;
#(
    parameter int SRC_N = NUM_SRC,
    parameter int LOW_N = LO_W,
    parameter int DW    = DATA_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SRC_N-1:0]      set_vec,
    input  logic                  wr,
    input  reg_sel_e              addr,
    input  logic [DW-1:0]         wdata,
    output logic [SRC_N-1:0]      sts,
    output logic [SRC_N-1:0]      en
);
    localparam int HIGH_N = SRC_N - LOW_N;

    logic [SRC_N-1:0] clr_vec;
    logic [SRC_N-1:0] sts_d;

    always_comb begin
        clr_vec = '0;
        if (wr && addr == REG_STS_LO) clr_vec[LOW_N-1:0]     = wdata[LOW_N-1:0];
        if (wr && addr == REG_STS_HI) clr_vec[SRC_N-1:LOW_N] = wdata[HIGH_N-1:0];
        sts_d = (sts & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= sts_d;
            if (wr && addr == REG_EN_LO) en[LOW_N-1:0]     <= wdata[LOW_N-1:0];
            if (wr && addr == REG_EN_HI) en[SRC_N-1:LOW_N] <= wdata[HIGH_N-1:0];
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((sts & $past(set_vec)) == $past(set_vec))); // R6

    AST_LO_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == REG_STS_LO) |=>
        ((sts[LOW_N-1:0] & $past(wdata[LOW_N-1:0]) & ~$past(set_vec[LOW_N-1:0])) == '0)); // R5

    AST_HI_UNTOUCHED_BY_LO: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == REG_STS_LO && set_vec[SRC_N-1:LOW_N] == '0) |=>
        $stable(sts[SRC_N-1:LOW_N])); // R5

    AST_STS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr && set_vec == '0) |=> $stable(sts)); // R3
endmodule

// File: rtl/isa_prio_enc.sv
`timescale 1ns/1ps
module isa_prio_enc
    import isa_agg_pkg::*;
#(
    parameter int SRC_N = NUM_SRC
) (
    input  logic [SRC_N-1:0] pending,
    output svc_t             svc
);
    logic [IDX_W-1:0] idx;
    logic             found;

    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (pending[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
        svc.valid = found;
        svc.irq   = found ? bit_to_irq(int'(idx)) : '0;
    end

    always_comb begin
        if (found) begin
            AST_PICK_PENDING: assert (pending[idx]); // R9
        end
    end
endmodule

// File: rtl/isa_irq_aggr.sv
`timescale 1ns/1ps
module isa_irq_aggr
    import isa_agg_pkg::*;
#(
    parameter int SRC_N = NUM_SRC,
    parameter int ISA_N = NUM_ISA,
    parameter int LOW_N = LO_W,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int IW    = IRQ_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [ISA_N-1:0] isa_irq,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          host_irq,
    output logic          svc_valid,
    output logic [IW-1:0] svc_irq
);
    localparam int HIGH_N = SRC_N - LOW_N;

    logic [SRC_N-1:0] src_lines;
    logic [SRC_N-1:0] rise;
    logic [SRC_N-1:0] sts;
    logic [SRC_N-1:0] en;
    logic [SRC_N-1:0] pending;
    svc_t             svc;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(reg_addr);

    for (genvar b = 0; b < SRC_N; b++) begin : g_map
        assign src_lines[b] = isa_irq[bit_to_irq(b)];
    end

    isa_edge_sync #(.WIDTH(SRC_N), .STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (src_lines),
        .rise (rise)
    );

    isa_status_regs #(.SRC_N(SRC_N), .LOW_N(LOW_N), .DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .set_vec (rise),
        .wr      (reg_wr),
        .addr    (sel),
        .wdata   (reg_wdata),
        .sts     (sts),
        .en      (en)
    );

    assign pending = sts & en;

    isa_prio_enc #(.SRC_N(SRC_N)) u_prio (
        .pending (pending),
        .svc     (svc)
    );

    assign host_irq  = |pending;
    assign svc_valid = svc.valid;
    assign svc_irq   = svc.irq;

    always_comb begin
        reg_rdata = '0;
        case (sel)
            REG_STS_LO: reg_rdata[LOW_N-1:0]  = sts[LOW_N-1:0];
            REG_STS_HI: reg_rdata[HIGH_N-1:0] = sts[SRC_N-1:LOW_N];
            REG_EN_LO:  reg_rdata[LOW_N-1:0]  = en[LOW_N-1:0];
            default:    reg_rdata[HIGH_N-1:0] = en[SRC_N-1:LOW_N];
        endcase
    end

    AST_SUMMARY_MATCHES_ENC: assert property (@(posedge clk) disable iff (rst)
        host_irq == svc_valid); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (sts == '0 && en == '0)); // R10
endmodule

// File: tb/isa_irq_aggr_bench.sv
`timescale 1ns/1ps
module isa_irq_aggr_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] isa_irq;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        host_irq;
    logic        svc_valid;
    logic [3:0]  svc_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    isa_irq_aggr u_isa_irq_aggr (
        .clk(clk), .rst(rst), .isa_irq(isa_irq), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_irq(host_irq), .svc_valid(svc_valid), .svc_irq(svc_irq)
    );

    // irq number, expected low status, expected high status, expect a pending source
    typedef struct packed {
        logic [3:0] irq;
        logic [7:0] lo;
        logic [7:0] hi;
        logic       v;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{4'd0,  8'h00, 8'h00, 1'b0}, '{4'd1,  8'h00, 8'h00, 1'b0},
        '{4'd2,  8'h00, 8'h00, 1'b0}, '{4'd3,  8'h01, 8'h00, 1'b1},
        '{4'd4,  8'h02, 8'h00, 1'b1}, '{4'd5,  8'h04, 8'h00, 1'b1},
        '{4'd6,  8'h08, 8'h00, 1'b1}, '{4'd7,  8'h10, 8'h00, 1'b1},
        '{4'd8,  8'h00, 8'h00, 1'b0}, '{4'd9,  8'h00, 8'h01, 1'b1},
        '{4'd10, 8'h20, 8'h00, 1'b1}, '{4'd11, 8'h40, 8'h00, 1'b1},
        '{4'd12, 8'h80, 8'h00, 1'b1}, '{4'd13, 8'h00, 8'h00, 1'b0},
        '{4'd14, 8'h00, 8'h02, 1'b1}, '{4'd15, 8'h00, 8'h04, 1'b1}
    };

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        isa_irq[n] = 1'b1;
        settle();
        isa_irq[n] = 1'b0;
        settle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hang expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; isa_irq = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        rd(2'd0, d); chk("R10 sts lo", d, 8'h00);
        rd(2'd1, d); chk("R10 sts hi", d, 8'h00);
        rd(2'd2, d); chk("R10 en lo", d, 8'h00);
        rd(2'd3, d); chk("R10 en hi", d, 8'h00);
        chk("R10 host_irq", host_irq, 0);

        // R7: enable read back
        wr(2'd2, 8'hFF); wr(2'd3, 8'h07);
        rd(2'd2, d); chk("R7 en lo", d, 8'hFF);
        rd(2'd3, d); chk("R7 en hi", d, 8'h07);

        // R1 R2 R4 R9: walk every ISA line
        for (int k = 0; k < 16; k++) begin
            pulse(int'(VECS[k].irq));
            rd(2'd0, d); chk("R1/R2 sts lo", d, VECS[k].lo);
            rd(2'd1, d); chk("R4 sts hi", d, VECS[k].hi);
            chk("R8 host_irq", host_irq, VECS[k].v);
            chk("R9 svc_irq", svc_irq, VECS[k].v ? VECS[k].irq : 4'd0);
            wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
            chk("R5 cleared", host_irq, 0);
        end

        // R11: latency of 4 edges
        @(negedge clk); isa_irq[3] = 1'b1;
        repeat (3) @(negedge clk);
        rd(2'd0, d); chk("R11 latency", d, 8'h01);
        isa_irq[3] = 1'b0;
        wr(2'd0, 8'h01);

        // R3: held level does not set again after clear
        @(negedge clk); isa_irq[5] = 1'b1;
        settle();
        rd(2'd0, d); chk("R3 first edge", d, 8'h04);
        wr(2'd0, 8'h04);
        settle();
        rd(2'd0, d); chk("R3 held level", d, 8'h00);
        isa_irq[5] = 1'b0;
        settle();

        // R5: separate acknowledge, zero bits clear nothing
        pulse(4); pulse(15);
        wr(2'd1, 8'hFF);
        rd(2'd0, d); chk("R5 lo kept", d, 8'h02);
        rd(2'd1, d); chk("R5 hi cleared", d, 8'h00);
        wr(2'd0, 8'h00);
        rd(2'd0, d); chk("R5 zero write", d, 8'h02);
        wr(2'd0, 8'h02);

        // R9: lowest bit first (IRQ 9 bit 8 vs IRQ 12 bit 7 vs IRQ 14 bit 9)
        pulse(14); pulse(9); pulse(12);
        chk("R9 prio 12", svc_irq, 4'd12);
        wr(2'd0, 8'h80);
        chk("R9 prio 9", svc_irq, 4'd9);
        wr(2'd1, 8'h01);
        chk("R9 prio 14", svc_irq, 4'd14);
        chk("R9 valid", svc_valid, 1);
        wr(2'd1, 8'h02);

        // R8: masked source
        wr(2'd2, 8'hDF);
        pulse(10);
        rd(2'd0, d); chk("R8 masked sts", d, 8'h20);
        chk("R8 masked host_irq", host_irq, 0);
        wr(2'd2, 8'hFF);
        chk("R8 enabled host_irq", host_irq, 1);
        chk("R9 enabled svc", svc_irq, 4'd10);
        wr(2'd0, 8'h20);

        // R6: set edge and clear in the same cycle
        pulse(6);
        @(negedge clk); isa_irq[3] = 1'b1;
        @(negedge clk); @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h09;
        @(negedge clk); reg_wr = 1'b0;
        rd(2'd0, d); chk("R6 set wins", d, 8'h01);
        isa_irq[3] = 1'b0;
        settle();

        // R10: reset mid-run
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        rd(2'd0, d); chk("R10 sts after reset", d, 8'h00);
        rd(2'd2, d); chk("R10 en after reset", d, 8'h00);
        chk("R10 host_irq after reset", host_irq, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule